// File: doc/BRIEF.md
# Four-Operation Flagged ALU

A purely combinational arithmetic-logic unit working on two operands of a configurable width (8 bits by default). A 2-bit operation select picks one of four functions: addition, subtraction, bitwise OR or bitwise AND. Alongside the result the unit gives two flags. The zero flag marks an all-zero result for every operation. The carry flag reports the carry out of the top bit, and only during addition.

Subtraction reuses the adder. The second operand is inverted and a carry-in of one is injected, so there is a single carry chain. The block has no clock and no state. A datapath drops it between its operand registers and its result register.

Top module: `flag_alu`

## Requirements
- R1: With op_sel = 2'b00, result equals (opnd_a + opnd_b) modulo 2^W.
- R2: With op_sel = 2'b01, result equals (opnd_a - opnd_b) modulo 2^W. For example, 0x00 - 0x01 gives 0xFF.
- R3: With op_sel = 2'b10, result equals the bitwise OR of opnd_a and opnd_b.
- R4: With op_sel = 2'b11, result equals the bitwise AND of opnd_a and opnd_b.
- R5: zero_flag is 1 exactly when all W bits of result are 0, for every op_sel value.
- R6: With op_sel = 2'b00, carry_flag equals bit W of the unsigned sum opnd_a + opnd_b.
- R7: With op_sel of 2'b01, 2'b10 or 2'b11, carry_flag is 0. This holds even when the shared adder produces an internal carry, as in 0x50 - 0x20.
- R8: Adding 0xFF and 0x01 gives result 0x00 with zero_flag 1 and carry_flag 1. Subtracting any operand from itself gives result 0x00 with zero_flag 1 and carry_flag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand (subtrahend for subtraction) |
| op_sel | input | 2 | Operation select: 00 add, 01 subtract, 10 OR, 11 AND |
| result | output | W | Result, truncated to W bits |
| zero_flag | output | 1 | 1 when result is all zeros |
| carry_flag | output | 1 | Carry out of the top bit for addition, else 0 |

## Verification
Fixed vectors give each operation one ordinary operand pair and one pair that reaches a boundary. For addition the boundaries are wrap-around with carry. For subtraction they are borrow and equal operands. For OR and AND they are complementary patterns that give all ones or all zeros. Subtraction with the minuend at least the subtrahend shows whether the adder's internal carry leaks onto carry_flag. Operands that give a zero result under each operation separate a correct zero flag from one tied to a single operation. A run of random operands under every opcode is then compared against an independent model to catch bit-slice and carry-chain errors that the fixed cases miss.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_OR  = 2'b10,
    OP_AND = 2'b11
  } alu_op_e;
endpackage

// File: rtl/flag_alu_addsub.sv
// Shared carry chain: subtract = a + ~b + 1
module flag_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] b_x;
  logic [W:0]   full;

  for (genvar i = 0; i < W; i++) begin : g_inv
    assign b_x[i] = b[i] ^ sub;
  end

  assign full = {1'b0, a} + {1'b0, b_x} + {{W{1'b0}}, sub};
  assign sum  = full[W-1:0];
  assign cout = full[W];
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_and,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = sel_and ? (a[i] & b[i]) : (a[i] | b[i]);
  end
endmodule

// File: rtl/flag_alu_zero.sv
module flag_alu_zero #(
  parameter int W = 8
) (
  input  logic [W-1:0] y,
  output logic         is_zero
);
  assign is_zero = ~|y;
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] result,
  output logic         zero_flag,
  output logic         carry_flag
);
  alu_op_e      op;
  logic [W-1:0] arith_y;
  logic         arith_c;
  logic [W-1:0] logic_y;

  assign op = alu_op_e'(op_sel);

  flag_alu_addsub #(.W(W)) u_addsub (
    .a   (opnd_a),
    .b   (opnd_b),
    .sub (op == OP_SUB),
    .sum (arith_y),
    .cout(arith_c)
  );

  flag_alu_logic #(.W(W)) u_logic (
    .a      (opnd_a),
    .b      (opnd_b),
    .sel_and(op == OP_AND),
    .y      (logic_y)
  );

  always_comb begin
    result     = '0;
    carry_flag = 1'b0;
    case (op)
      OP_ADD: begin
        result     = arith_y;
        carry_flag = arith_c;
      end
      OP_SUB:  result = arith_y;
      OP_OR,
      OP_AND:  result = logic_y;
      default: begin
        result     = '0;
        carry_flag = 1'b0;
      end
    endcase
  end

  flag_alu_zero #(.W(W)) u_zero (
    .y      (result),
    .is_zero(zero_flag)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [1:0]   op_sel,
  input logic [W-1:0] result,
  input logic         zero_flag,
  input logic         carry_flag
);
  always_comb begin
    if (op_sel == 2'b00) begin
      // R1 and R6 together: carry and result form the full sum
      assert_sum_R1: assert ({carry_flag, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}));
    end
    if (op_sel == 2'b01) begin
      assert_diff_R2: assert (result == W'(opnd_a - opnd_b));
    end
    if (op_sel == 2'b10) begin
      assert_or_R3: assert (result == (opnd_a | opnd_b));
    end
    if (op_sel == 2'b11) begin
      assert_and_R4: assert (result == (opnd_a & opnd_b));
    end
    if (op_sel != 2'b00) begin
      assert_no_carry_R7: assert (!carry_flag);
    end
    if (result != '0) begin
      assert_zero_clear_R5: assert (!zero_flag);
    end
  end
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_flag_alu_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .op_sel    (op_sel),
  .result    (result),
  .zero_flag (zero_flag),
  .carry_flag(carry_flag)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;
  localparam int W = 8;
  localparam int NV = 12;
  localparam int NRAND = 400;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] opnd_a, opnd_b, result;
  logic [1:0]   op_sel;
  logic         zero_flag, carry_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  flag_alu #(.W(W)) i_flag_alu (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sel    (op_sel),
    .result    (result),
    .zero_flag (zero_flag),
    .carry_flag(carry_flag)
  );

  // {op, a, b, y, z, c}
  localparam logic [27:0] VEC [NV] = '{
    {2'b00, 8'h12, 8'h34, 8'h46, 1'b0, 1'b0},  // R1
    {2'b00, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},  // R1 R6
    {2'b00, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1},  // R8
    {2'b00, 8'hC8, 8'h64, 8'h2C, 1'b0, 1'b1},  // R6
    {2'b01, 8'h50, 8'h20, 8'h30, 1'b0, 1'b0},  // R2 R7
    {2'b01, 8'h20, 8'h50, 8'hD0, 1'b0, 1'b0},  // R2
    {2'b01, 8'h7F, 8'h7F, 8'h00, 1'b1, 1'b0},  // R8
    {2'b10, 8'hA5, 8'h5A, 8'hFF, 1'b0, 1'b0},  // R3
    {2'b10, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0},  // R3 R5
    {2'b11, 8'hA5, 8'h5A, 8'h00, 1'b1, 1'b0},  // R4 R5
    {2'b11, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0},  // R4
    {2'b01, 8'h00, 8'h01, 8'hFF, 1'b0, 1'b0}   // R2
  };

  function automatic logic [W+1:0] model(input logic [1:0] op,
                                         input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [W:0]   s;
    logic [W-1:0] y;
    logic         c;
    s = {1'b0, a} + {1'b0, b};
    c = 1'b0;
    case (op)
      2'b00:   begin y = s[W-1:0]; c = s[W]; end
      2'b01:   y = a - b;
      2'b10:   y = a | b;
      default: y = a & b;
    endcase
    return {y, (y == '0), c};
  endfunction

  task automatic apply(input logic [1:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W+1:0] exp,
                       input string req);
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    checks++;
    if ({result, zero_flag, carry_flag} !== exp) begin
      fails++;
      $display("FAIL %s: op=%b a=%h b=%h got y=%h z=%b c=%b expected y=%h z=%b c=%b",
               req, op, a, b, result, zero_flag, carry_flag,
               exp[W+1:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    op_sel = 2'b00; opnd_a = '0; opnd_b = '0;
    // idle state: all-zero inputs under add (R5 R6)
    apply(2'b00, 8'h00, 8'h00, {8'h00, 1'b1, 1'b0}, "R5");
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][27:26], VEC[i][25:18], VEC[i][17:10], VEC[i][9:0], "R1-vector");
    end
    // R8: self-subtraction for several values
    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] v;
      v = W'(i * 8'h55);
      apply(2'b01, v, v, {8'h00, 1'b1, 1'b0}, "R8");
    end
    // R7: OR/AND never raise carry, even with all-ones operands
    apply(2'b10, 8'hFF, 8'hFF, {8'hFF, 1'b0, 1'b0}, "R7");
    apply(2'b11, 8'hFF, 8'hFF, {8'hFF, 1'b0, 1'b0}, "R7");
    // random sweep against model for every opcode (R1 R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < NRAND; i++) begin
      logic [1:0]   op;
      logic [W-1:0] a, b;
      op = 2'(i % 4);
      a  = W'($urandom);
      b  = W'($urandom);
      apply(op, a, b, model(op, a, b), "R1R2R3R4-random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule